// File: doc/BRIEF.md
# Peripheral Power Mode Controller

This block decides which of four power states a peripheral logic domain sits in: full power, doze, nap or sleep. Software-visible mode bits (a global enable and three mode selects) ask for a low-power state. A request from the processor says that it is itself going into a low-power state. Together they decide when the domain may power down. Four wake sources bring it back to full power: an asynchronous hard reset, an active-low bus request line, a bus address hit and a non-maskable interrupt.

The controller drives the current state as a 2-bit code and a one-hot vector. It also drives three clock-enable lines that a clock-gating stage outside the block uses. The lines are the core clock, the peripheral clock and the bus snoop clock. Each deeper state turns off one more of them. The bus request, address hit and interrupt inputs come from other clock domains, so they pass through a configurable synchronizer before the state machine sees them. The mode bits and the processor request are taken as already synchronous.

Top module: `pm_ctrl`

## Requirements
- R1: Holding `rst` high at a rising clock edge, or raising `hard_rst` at any time without waiting for a clock edge, puts the block in full power: `state_o` = 00, `state_onehot_o` = 0001, `clk_en_o` = 111.
- R2: While `pm_enable` is 0 the block stays in full power, whatever the select bits and the processor request are.
- R3: From full power, `pm_enable` = 1 with `doze_sel` = 1 moves the block to doze (code 01) at the next rising edge, whether or not the processor request is present.
- R4: Nap (code 10) is entered from full power at the next edge only when `pm_enable`, `nap_sel` and `cpu_lp_req` are all 1. Without `cpu_lp_req` the block does not enter nap.
- R5: Sleep (code 11) is entered from full power at the next edge only when `pm_enable`, `sleep_sel` and `cpu_lp_req` are all 1.
- R6: When more than one select bit is set, the deepest state whose conditions hold is chosen: sleep, then nap, then doze. For example, sleep and doze selected without `cpu_lp_req` gives doze.
- R7: In doze or nap, `bus_req_n` low, `addr_hit` high or `nmi` high returns the block to full power at the third rising edge after the input changes. Two of those edges are spent in the synchronizer.
- R8: In sleep, only `bus_req_n` low or `nmi` high wakes the block, with the same three-edge delay. `addr_hit` has no effect on sleep and does not block entry to it.
- R9: In nap or sleep, `cpu_lp_req` falling to 0 returns the block to full power at the next edge. Doze does not depend on `cpu_lp_req`.
- R10: A low-power state never moves directly to another low-power state. It stays where it is or goes to full power, even if the select bits change.
- R11: The outputs follow the state. `state_onehot_o` has exactly one bit set, at the index equal to the state code. In `clk_en_o`, bit 0 (core) is 1 only in full power, bit 1 (peripheral) is 1 in full power and doze, and bit 2 (snoop) is 1 in full power, doze and nap. In sleep all three bits are 0.
- R12: Entry is withheld while a synchronized wake source that would exit the target state is active. Entry proceeds at the third edge after that source goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_rst | input | 1 | Asynchronous active-high hard reset, highest priority |
| pm_enable | input | 1 | Global power-management enable |
| doze_sel | input | 1 | Doze select |
| nap_sel | input | 1 | Nap select |
| sleep_sel | input | 1 | Sleep select |
| cpu_lp_req | input | 1 | Processor is requesting nap or sleep |
| bus_req_n | input | 1 | Active-low bus request (asynchronous) |
| addr_hit | input | 1 | Bus address hit (asynchronous) |
| nmi | input | 1 | Non-maskable interrupt (asynchronous) |
| state_o | output | 2 | State code: 00 full, 01 doze, 10 nap, 11 sleep |
| state_onehot_o | output | 4 | One-hot state, bit index equals the code |
| clk_en_o | output | 3 | Clock enables: bit 0 core, bit 1 peripheral, bit 2 snoop |

## Verification
The outputs are decoded combinationally from the state register. A change on a mode bit or on `cpu_lp_req` therefore shows at the first rising edge after it. A change on a wake line shows at the third rising edge, and a hard reset shows at once, with no edge. The bench drives every input on the falling edge and samples on the falling edge that follows the edge where the result is due. For wake sources it also samples one edge earlier, to confirm that the state has not yet moved. Each hard-reset check is taken one nanosecond after assertion, before any clock edge occurs.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

    localparam int unsigned PM_NUM_STATES = 4;
    localparam int unsigned PM_STATE_W    = $clog2(PM_NUM_STATES);
    localparam int unsigned PM_NUM_WAKE   = 3;
    localparam int unsigned PM_NUM_CLKS   = 3;

    // Codes are visible at the ports; order is depth of power saving.
    typedef enum logic [PM_STATE_W-1:0] {
        PM_FULL  = 2'b00,
        PM_DOZE  = 2'b01,
        PM_NAP   = 2'b10,
        PM_SLEEP = 2'b11
    } pm_state_e;

    // Mode request bits as presented by the control register.
    typedef struct packed {
        logic enable;
        logic sleep_sel;
        logic nap_sel;
        logic doze_sel;
    } pm_mode_t;

    // Synchronized wake sources, all active-high after conditioning.
    typedef struct packed {
        logic nmi;
        logic addr_hit;
        logic bus_req;
    } pm_wake_t;

    // Exit conditions summarised per depth class.
    typedef struct packed {
        logic light;  // exits doze and nap
        logic deep;   // exits sleep
    } pm_exit_t;

    // Clock-enable bundle; bit order matches clk_en_o.
    typedef struct packed {
        logic snoop;
        logic periph;
        logic core;
    } pm_clken_t;

    // Deepest permitted target from full power, ignoring wake blocking.
    function automatic pm_state_e pm_entry_target(pm_mode_t m, logic cpu_lp);
        pm_state_e t;
        t = PM_FULL;
        if (m.enable) begin
            if (m.sleep_sel && cpu_lp)     t = PM_SLEEP;
            else if (m.nap_sel && cpu_lp)  t = PM_NAP;
            else if (m.doze_sel)           t = PM_DOZE;
        end
        return t;
    endfunction

    // Each deeper state drops one more clock.
    function automatic pm_clken_t pm_clk_enables(pm_state_e s);
        pm_clken_t e;
        e.core   = (s == PM_FULL);
        e.periph = (s == PM_FULL) || (s == PM_DOZE);
        e.snoop  = (s != PM_SLEEP);
        return e;
    endfunction

    // Whether a given exit summary releases a given low-power state.
    function automatic logic pm_exit_hits(pm_state_e s, pm_exit_t x);
        logic hit;
        unique case (s)
            PM_DOZE, PM_NAP: hit = x.light;
            PM_SLEEP:        hit = x.deep;
            default:         hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pm_sync.sv
`timescale 1ns/1ps
module pm_sync #(
    parameter int unsigned       WIDTH   = 1,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pm_wake_decode.sv
`timescale 1ns/1ps
module pm_wake_decode
    import pm_pkg::*;
(
    input  pm_wake_t wake,
    output pm_exit_t exits
);

    // Address hits only matter while the snoop clock is running (doze/nap).
    always_comb begin
        exits.deep  = wake.bus_req | wake.nmi;
        exits.light = exits.deep | wake.addr_hit;
    end

endmodule

// File: rtl/pm_fsm.sv
`timescale 1ns/1ps
module pm_fsm
    import pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hard_rst,
    input  pm_mode_t  mode,
    input  logic      cpu_lp,
    input  pm_exit_t  exits,
    output pm_state_e state
);

    pm_state_e state_q;
    pm_state_e state_d;
    pm_state_e target;

    always_comb begin
        target  = pm_entry_target(mode, cpu_lp);
        state_d = state_q;
        unique case (state_q)
            PM_FULL: begin
                if (target != PM_FULL && !pm_exit_hits(target, exits))
                    state_d = target;
            end
            PM_DOZE: begin
                if (pm_exit_hits(PM_DOZE, exits)) state_d = PM_FULL;
            end
            PM_NAP, PM_SLEEP: begin
                if (pm_exit_hits(state_q, exits) || !cpu_lp) state_d = PM_FULL;
            end
            default: state_d = PM_FULL;
        endcase
    end

    always_ff @(posedge clk or posedge hard_rst) begin
        if (hard_rst)  state_q <= PM_FULL;
        else if (rst)  state_q <= PM_FULL;
        else           state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/pm_ctrl.sv
`timescale 1ns/1ps
module pm_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hard_rst,
    input  logic                     pm_enable,
    input  logic                     doze_sel,
    input  logic                     nap_sel,
    input  logic                     sleep_sel,
    input  logic                     cpu_lp_req,
    input  logic                     bus_req_n,
    input  logic                     addr_hit,
    input  logic                     nmi,
    output logic [PM_STATE_W-1:0]    state_o,
    output logic [PM_NUM_STATES-1:0] state_onehot_o,
    output logic [PM_NUM_CLKS-1:0]   clk_en_o
);

    // Raw wake pins in sync order {nmi, addr_hit, bus_req_n}; idle value 001.
    localparam logic [PM_NUM_WAKE-1:0] WAKE_IDLE = 3'b001;

    logic [PM_NUM_WAKE-1:0] wake_raw;
    logic [PM_NUM_WAKE-1:0] wake_sync;
    pm_wake_t               wake;
    pm_exit_t               exits;
    pm_mode_t               mode;
    pm_state_e              state;
    pm_clken_t              clken;

    assign wake_raw = {nmi, addr_hit, bus_req_n};

    pm_sync #(
        .WIDTH   (PM_NUM_WAKE),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (WAKE_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (wake_raw),
        .q   (wake_sync)
    );

    always_comb begin
        wake.nmi      = wake_sync[2];
        wake.addr_hit = wake_sync[1];
        wake.bus_req  = ~wake_sync[0];
        mode.enable    = pm_enable;
        mode.sleep_sel = sleep_sel;
        mode.nap_sel   = nap_sel;
        mode.doze_sel  = doze_sel;
    end

    pm_wake_decode u_dec (
        .wake  (wake),
        .exits (exits)
    );

    pm_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .hard_rst (hard_rst),
        .mode     (mode),
        .cpu_lp   (cpu_lp_req),
        .exits    (exits),
        .state    (state)
    );

    assign state_o = state;

    for (genvar i = 0; i < PM_NUM_STATES; i++) begin : g_onehot
        assign state_onehot_o[i] = (state_o == PM_STATE_W'(i));
    end

    assign clken    = pm_clk_enables(state);
    assign clk_en_o = clken;

endmodule

// File: rtl/pm_ctrl_chk.sv
`timescale 1ns/1ps
module pm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       hard_rst,
    input logic       pm_enable,
    input logic       cpu_lp_req,
    input logic [1:0] state_o,
    input logic [3:0] state_onehot_o,
    input logic [2:0] clk_en_o
);

    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (rst || hard_rst)
        (state_o == 2'b00 && !pm_enable) |=> (state_o == 2'b00));

    assert_nap_needs_cpu_R4: assert property (@(posedge clk) disable iff (rst || hard_rst)
        (state_o == 2'b10 && $past(state_o) == 2'b00) |-> $past(cpu_lp_req));

    assert_sleep_needs_cpu_R5: assert property (@(posedge clk) disable iff (rst || hard_rst)
        (state_o == 2'b11 && $past(state_o) == 2'b00) |-> $past(cpu_lp_req));

    assert_cpu_drop_exit_R9: assert property (@(posedge clk) disable iff (rst || hard_rst)
        (state_o[1] && !cpu_lp_req) |=> (state_o == 2'b00));

    assert_exit_to_full_R10: assert property (@(posedge clk) disable iff (rst || hard_rst)
        (state_o != 2'b00) |=> (state_o == 2'b00 || $stable(state_o)));

    assert_onehot_R11: assert property (@(posedge clk) disable iff (rst || hard_rst)
        ($countones(state_onehot_o) == 1) && state_onehot_o[state_o]);

    assert_sleep_gated_R11: assert property (@(posedge clk) disable iff (rst || hard_rst)
        (state_o == 2'b11) |-> (clk_en_o == 3'b000));

    assert_full_clocks_R11: assert property (@(posedge clk) disable iff (rst || hard_rst)
        (state_o == 2'b00) |-> (clk_en_o == 3'b111));

endmodule

bind pm_ctrl pm_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .hard_rst       (hard_rst),
    .pm_enable      (pm_enable),
    .cpu_lp_req     (cpu_lp_req),
    .state_o        (state_o),
    .state_onehot_o (state_onehot_o),
    .clk_en_o       (clk_en_o)
);

// File: tb/sim_pm_ctrl.sv
`timescale 1ns/1ps
module sim_pm_ctrl;

    localparam logic [1:0] S_FULL = 2'b00, S_DOZE = 2'b01, S_NAP = 2'b10, S_SLEEP = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1, hard_rst = 1'b0;
    logic pm_enable = 0, doze_sel = 0, nap_sel = 0, sleep_sel = 0, cpu_lp_req = 0;
    logic bus_req_n = 1, addr_hit = 0, nmi = 0;
    logic [1:0] state_o;
    logic [3:0] state_onehot_o;
    logic [2:0] clk_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pm_ctrl u0 (
        .clk(clk), .rst(rst), .hard_rst(hard_rst),
        .pm_enable(pm_enable), .doze_sel(doze_sel), .nap_sel(nap_sel),
        .sleep_sel(sleep_sel), .cpu_lp_req(cpu_lp_req),
        .bus_req_n(bus_req_n), .addr_hit(addr_hit), .nmi(nmi),
        .state_o(state_o), .state_onehot_o(state_onehot_o), .clk_en_o(clk_en_o)
    );

    // Clock enables per R11.
    function automatic logic [2:0] exp_en(logic [1:0] s);
        case (s)
            S_FULL:  return 3'b111;
            S_DOZE:  return 3'b110;
            S_NAP:   return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_state(logic [1:0] exp, string req);
        logic [3:0] oh;
        oh = 4'b0001 << exp;
        checks++;
        if (state_o !== exp) begin
            fails++;
            $display("FAIL %s state: actual=%b expected=%b", req, state_o, exp);
        end
        checks++;
        if (state_onehot_o !== oh || clk_en_o !== exp_en(exp)) begin
            fails++;
            $display("FAIL R11 (%s) onehot/clk_en: actual=%b/%b expected=%b/%b",
                     req, state_onehot_o, clk_en_o, oh, exp_en(exp));
        end
    endtask

    task automatic do_reset();
        rst = 1; pm_enable = 0; doze_sel = 0; nap_sel = 0; sleep_sel = 0;
        cpu_lp_req = 0; bus_req_n = 1; addr_hit = 0; nmi = 0; hard_rst = 0;
        step(2);
        rst = 0;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        check_state(S_FULL, "R1 sync reset");
    endtask

    task automatic t_enable_gate();
        do_reset();
        doze_sel = 1; nap_sel = 1; sleep_sel = 1; cpu_lp_req = 1;
        step(3);
        check_state(S_FULL, "R2 enable off");
    endtask

    task automatic t_doze();
        do_reset();
        pm_enable = 1; doze_sel = 1;
        step(1);
        check_state(S_DOZE, "R3 doze entry");
        doze_sel = 0; cpu_lp_req = 1; step(1); cpu_lp_req = 0;
        step(2);
        check_state(S_DOZE, "R9 doze ignores cpu");
        addr_hit = 1;
        step(2);
        check_state(S_DOZE, "R7 addr hit in sync");
        step(1);
        check_state(S_FULL, "R7 addr hit wakes doze");
    endtask

    task automatic t_nap();
        do_reset();
        pm_enable = 1; nap_sel = 1;
        step(2);
        check_state(S_FULL, "R4 nap without cpu");
        cpu_lp_req = 1;
        step(1);
        check_state(S_NAP, "R4 nap entry");
        bus_req_n = 0;
        step(2);
        check_state(S_NAP, "R7 bus req in sync");
        step(1);
        check_state(S_FULL, "R7 bus req wakes nap");
        step(1);
        check_state(S_FULL, "R12 entry withheld");
        bus_req_n = 1;
        step(2);
        check_state(S_FULL, "R12 still withheld");
        step(1);
        check_state(S_NAP, "R12 entry resumes");
        cpu_lp_req = 0;
        step(1);
        check_state(S_FULL, "R9 nap cpu drop");
    endtask

    task automatic t_sleep();
        do_reset();
        pm_enable = 1; sleep_sel = 1; cpu_lp_req = 1;
        step(1);
        check_state(S_SLEEP, "R5 sleep entry");
        addr_hit = 1;
        step(4);
        check_state(S_SLEEP, "R8 addr hit ignored");
        addr_hit = 0;
        step(3);
        nmi = 1;
        step(2);
        check_state(S_SLEEP, "R8 nmi in sync");
        step(1);
        check_state(S_FULL, "R8 nmi wakes sleep");
        step(1);
        check_state(S_FULL, "R12 nmi withholds sleep");
        // addr hit held active does not block sleep
        do_reset();
        addr_hit = 1;
        step(3);
        pm_enable = 1; sleep_sel = 1; cpu_lp_req = 1;
        step(1);
        check_state(S_SLEEP, "R8 addr hit no block");
        cpu_lp_req = 0;
        step(1);
        check_state(S_FULL, "R9 sleep cpu drop");
    endtask

    task automatic t_priority();
        do_reset();
        pm_enable = 1; doze_sel = 1; nap_sel = 1; sleep_sel = 1; cpu_lp_req = 1;
        step(1);
        check_state(S_SLEEP, "R6 sleep wins");
        do_reset();
        pm_enable = 1; doze_sel = 1; nap_sel = 1; cpu_lp_req = 1;
        step(1);
        check_state(S_NAP, "R6 nap over doze");
        do_reset();
        pm_enable = 1; doze_sel = 1; sleep_sel = 1;
        step(1);
        check_state(S_DOZE, "R6 doze without cpu");
    endtask

    task automatic t_no_direct();
        do_reset();
        pm_enable = 1; doze_sel = 1;
        step(1);
        check_state(S_DOZE, "R3 doze before switch");
        sleep_sel = 1; nap_sel = 1; cpu_lp_req = 1;
        step(3);
        check_state(S_DOZE, "R10 no direct move");
        nmi = 1;
        step(3);
        check_state(S_FULL, "R10 exits to full");
    endtask

    task automatic t_hard_reset();
        do_reset();
        pm_enable = 1; nap_sel = 1; cpu_lp_req = 1;
        step(1);
        check_state(S_NAP, "R4 nap before hard reset");
        hard_rst = 1; pm_enable = 0;
        #1;
        check_state(S_FULL, "R1 hard reset async");
        #0.5 hard_rst = 0;
        step(1);
        check_state(S_FULL, "R1 after hard reset");
    endtask

    initial begin
        t_reset();
        t_enable_gate();
        t_doze();
        t_nap();
        t_sleep();
        t_priority();
        t_no_direct();
        t_hard_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule